// File: doc/BRIEF.md
# Configurable GPIO Port Interrupt Controller

This block manages four 8-bit general-purpose pin ports behind a small register bus. Each port has an output latch, a per-pin interrupt enable mask and a 2-bit mode field. The mode field selects how the port drives its pins and which edge direction counts as an event. Pin inputs pass through a two-flop synchronizer. The selected edge on an enabled pin sets a sticky pending bit, and a single interrupt request is raised while any pending bit is set. Software clears pending bits by writing ones to them.

The register bus is plain control access. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. There is no back-pressure, and each access completes in one cycle. The pins carry no stream, so no valid/ready pair is used anywhere.

Register addresses (default parameters): 0x00–0x03 hold the port data registers, 0x04–0x07 the interrupt enables, 0x08 the mode register, and 0x09–0x0C the pending registers. Mode encoding: 00 = open-drain with rising-edge events, 01 = open-drain with falling-edge events, 10 = pulled-up input with rising-edge events, 11 = push-pull output with no events. Port p uses bits [2p+1:2p] of the mode register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, every pending register reads 0x00, `irq` is low, `pin_oe` and `pin_out` are all zero, and all interrupt enables are clear, so pin edges set no pending bit.
- R2: Per port, modes 00 and 01 give `pin_oe` = inverted output latch and `pin_out` = 0. Mode 10 gives `pin_oe` = 0. Mode 11 gives `pin_oe` = all ones and `pin_out` = the output latch.
- R3: In modes 00 and 10, a 0-to-1 change on an enabled pin sets its pending bit and a 1-to-0 change does not. `irq` is still low after the second rising clock edge following the change and is high after the third.
- R4: In mode 01, a 1-to-0 change on an enabled pin sets its pending bit and a 0-to-1 change does not.
- R5: In mode 11, no pin of that port sets a pending bit, whatever its enable bits hold.
- R6: A pin whose enable bit (address 0x04+p, bit n for pin n of port p) is 0 never sets its pending bit.
- R7: Pending bits stay set until cleared. Writing 1 to a bit of pending register 0x09+p clears only that bit. `irq` is high exactly while any pending bit of any port is set.
- R8: A read of data register 0x00+p returns the synchronized pin levels of port p, not the value last written.
- R9: Enable registers are write-only and read as 0x00.
- R10: The mode register at 0x08 reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels, port p at bits [8p+7:8p] |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output level |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` is asynchronous but holds each level for at least a few cycles. They also assume that bus writes only target mapped addresses, and that reset is held for at least one clock edge before any access. The stimulus changes pins only at falling clock edges and leaves four or more cycles between changes. It issues single-cycle writes separated by idle cycles, and it holds reset over the first edges. This keeps every sticky-bit and enable-gating check free of overlapping events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    MODE_OD_RISE  = 2'b00,
    MODE_OD_FALL  = 2'b01,
    MODE_IN_RISE  = 2'b10,
    MODE_PUSHPULL = 2'b11
  } pin_mode_e;

  // Events are armed in every mode except push-pull.
  function automatic logic mode_armed(pin_mode_e m);
    return m != MODE_PUSHPULL;
  endfunction

  // Only one mode watches falling edges.
  function automatic logic mode_falling(pin_mode_e m);
    return m == MODE_OD_FALL;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  pin_mode_e    mode,
  input  logic [W-1:0] level,
  input  logic [W-1:0] wdata,
  input  logic         wr_latch,
  input  logic         wr_enable,
  input  logic         wr_clear,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] latch_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  // Output latch and enable mask
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      en_q    <= '0;
    end else begin
      if (wr_latch)  latch_q <= wdata;
      if (wr_enable) en_q    <= wdata;
    end
  end

  // Edge detection against the previous synchronized level
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  always_comb begin
    if (mode_falling(mode)) edge_hit = prev_q & ~level;
    else                    edge_hit = level & ~prev_q;
    set_mask = edge_hit & en_q & {W{mode_armed(mode)}};
    clr_mask = wr_clear ? wdata : '0;
  end

  // Sticky pending bits; a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  // Pin drive per mode
  always_comb begin
    unique case (mode)
      MODE_OD_RISE, MODE_OD_FALL: begin
        oe  = ~latch_q;
        out = '0;
      end
      MODE_IN_RISE: begin
        oe  = '0;
        out = '0;
      end
      default: begin
        oe  = '1;
        out = latch_q;
      end
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic                        irq
);
  localparam int PINS      = NUM_PORTS * PORT_W;
  localparam int CFG_W     = 2 * NUM_PORTS;
  localparam int DATA_BASE = 0;
  localparam int EN_BASE   = NUM_PORTS;
  localparam int CFG_ADDR  = 2 * NUM_PORTS;
  localparam int STAT_BASE = 2 * NUM_PORTS + 1;

  logic [CFG_W-1:0] cfg_q;
  logic [PINS-1:0]  level_all;
  logic [PINS-1:0]  en_all;
  logic [PINS-1:0]  pend_all;

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pin_in),
    .synced (level_all)
  );

  // Mode register: resets to open-drain, rising-edge on every port
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_latch, wr_enable, wr_clear;
    assign wr_latch  = bus_wr && (bus_addr == ADDR_W'(DATA_BASE + p));
    assign wr_enable = bus_wr && (bus_addr == ADDR_W'(EN_BASE + p));
    assign wr_clear  = bus_wr && (bus_addr == ADDR_W'(STAT_BASE + p));

    gpio_port_slice #(.W(PORT_W)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .mode      (pin_mode_e'(cfg_q[2*p +: 2])),
      .level     (level_all[p*PORT_W +: PORT_W]),
      .wdata     (bus_wdata),
      .wr_latch  (wr_latch),
      .wr_enable (wr_enable),
      .wr_clear  (wr_clear),
      .oe        (pin_oe[p*PORT_W +: PORT_W]),
      .out       (pin_out[p*PORT_W +: PORT_W]),
      .en_q      (en_all[p*PORT_W +: PORT_W]),
      .pend_q    (pend_all[p*PORT_W +: PORT_W])
    );
  end

  // Read mux; enable registers are write-only and read as zero
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(DATA_BASE + p)) bus_rdata = level_all[p*PORT_W +: PORT_W];
      if (bus_addr == ADDR_W'(STAT_BASE + p)) bus_rdata = pend_all[p*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(CFG_ADDR)) bus_rdata[CFG_W-1:0] = cfg_q;
  end

  assign irq = |pend_all;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [PORT_W-1:0]           bus_wdata,
  input logic [2*NUM_PORTS-1:0]      cfg_q,
  input logic [NUM_PORTS*PORT_W-1:0] en_q,
  input logic [NUM_PORTS*PORT_W-1:0] pend_q,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic                        irq
);
  localparam int PINS      = NUM_PORTS * PORT_W;
  localparam int STAT_BASE = 2 * NUM_PORTS + 1;

  logic [PINS-1:0] clr_mask;
  logic [PINS-1:0] pp_mask;
  logic [PINS-1:0] in_mask;

  always_comb begin
    clr_mask = '0;
    pp_mask  = '0;
    in_mask  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_wr && bus_addr == ADDR_W'(STAT_BASE + p)) clr_mask[p*PORT_W +: PORT_W] = bus_wdata;
      if (cfg_q[2*p +: 2] == 2'b11) pp_mask[p*PORT_W +: PORT_W] = '1;
      if (cfg_q[2*p +: 2] == 2'b10) in_mask[p*PORT_W +: PORT_W] = '1;
    end
  end

  // R1: reset leaves the request low, pins released and modes at zero
  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (!irq && pin_oe == '0 && cfg_q == '0));

  // R2: a pulled-up input port never enables its drivers
  p_input_released_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & in_mask) == '0);

  // R5: a push-pull port gains no pending bit
  p_pushpull_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & $past(pp_mask)) == '0));

  // R6: only enabled pins gain pending bits
  p_pend_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R7: a pending bit only drops on a write-one clear
  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0));

  // R7: any pending bit holds the request high
  p_pend_raises_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0) |-> irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cfg_q     (cfg_q),
  .en_q      (en_all),
  .pend_q    (pend_all),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe;
  logic [31:0] pin_out;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  gpio_irq_ctrl u_dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
    .pin_oe (pin_oe), .pin_out (pin_out), .irq (irq)
  );

  always #5 clk = ~clk;

  // Vector: {mode[1:0], enable, level before, level after, expected pending}
  localparam int NV = 8;
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 8'hFF, 8'h00, 8'h0F, 8'h0F},
    {2'b00, 8'hFF, 8'hFF, 8'hF0, 8'h00},
    {2'b01, 8'hFF, 8'hFF, 8'h0F, 8'hF0},
    {2'b01, 8'hFF, 8'h00, 8'hFF, 8'h00},
    {2'b10, 8'hFF, 8'h00, 8'hFF, 8'hFF},
    {2'b11, 8'hFF, 8'h00, 8'hFF, 8'h00},
    {2'b11, 8'hFF, 8'hFF, 8'h00, 8'h00},
    {2'b00, 8'h3C, 8'h00, 8'hFF, 8'h3C}
  };
  localparam int VREQ [NV] = '{3, 3, 4, 4, 3, 5, 5, 6};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    rd(4'h8, r); check("R1 mode reg", {24'b0, r}, 32'h0);
    for (int p = 0; p < 4; p++) begin
      rd(4'(9 + p), r); check("R1 pending", {24'b0, r}, 32'h0);
    end
    set_pins(32'hFFFF_FFFF); settle();
    rd(4'h9, r); check("R1 enables clear", {24'b0, r}, 32'h0);
    check("R1 no irq after edges", {31'b0, irq}, 32'h0);
    set_pins(32'h0); settle();

    // Table walk on port 0 (R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      wr(4'h8, {6'b0, VEC[i][33:32]});
      wr(4'h4, VEC[i][31:24]);
      set_pins({24'b0, VEC[i][23:16]}); settle();
      wr(4'h9, 8'hFF);
      set_pins({24'b0, VEC[i][15:8]}); settle();
      rd(4'h9, r);
      check($sformatf("R%0d vector %0d", VREQ[i], i), {24'b0, r}, {24'b0, VEC[i][7:0]});
      wr(4'h9, 8'hFF);
    end
    wr(4'h4, 8'h00);
    wr(4'h8, 8'h00);
    set_pins(32'h0); settle();

    // R3 latency: low after two edges, high after the third
    wr(4'h4, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R3 irq before third edge", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R3 irq after third edge", {31'b0, irq}, 32'h1);
    wr(4'h9, 8'hFF);

    // R7 sticky, selective clear, OR across ports
    wr(4'h4, 8'hFF);
    set_pins(32'h0000_0006); settle();
    rd(4'h9, r); check("R7 pending set", {24'b0, r}, 32'h06);
    wr(4'h9, 8'h02);
    rd(4'h9, r); check("R7 selective clear", {24'b0, r}, 32'h04);
    check("R7 irq held", {31'b0, irq}, 32'h1);
    wr(4'h9, 8'h04);
    check("R7 irq drops", {31'b0, irq}, 32'h0);
    wr(4'h7, 8'h80);
    set_pins(32'h8000_0006); settle();
    rd(4'hC, r); check("R7 port3 pending", {24'b0, r}, 32'h80);
    check("R7 irq from port3", {31'b0, irq}, 32'h1);
    wr(4'hC, 8'h80);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);

    // R2 drive modes on port 1
    wr(4'h1, 8'hA5);
    check("R2 open-drain oe", {24'b0, pin_oe[15:8]}, 32'h5A);
    check("R2 open-drain out", {24'b0, pin_out[15:8]}, 32'h00);
    wr(4'h8, 8'b0000_1100);
    check("R2 push-pull oe", {24'b0, pin_oe[15:8]}, 32'hFF);
    check("R2 push-pull out", {24'b0, pin_out[15:8]}, 32'hA5);
    wr(4'h8, 8'b0000_1000);
    check("R2 input oe", {24'b0, pin_oe[15:8]}, 32'h00);

    // R10 mode readback
    wr(4'h8, 8'h1B);
    rd(4'h8, r); check("R10 mode readback", {24'b0, r}, 32'h1B);

    // R8 data read returns pin levels
    wr(4'h2, 8'h00);
    set_pins(32'h003C_0000); settle();
    rd(4'h2, r); check("R8 data read", {24'b0, r}, 32'h3C);

    // R9 enable write-only
    wr(4'h5, 8'hFF);
    rd(4'h5, r); check("R9 enable reads zero", {24'b0, r}, 32'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule